// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. Software loads an address register and, for short-form (Clause 22) accesses, a one-hot port mask, then writes a command word with its busy bit set. The block generates the MDC clock from the system clock, shifts out a 32-bit preamble of ones and the management frame(s) on MDIO, releases the line for the turnaround and data of a read, and collects the 16 returned bits into the data field of the command word. Busy clears when the last frame ends.

Long-form (Clause 45) accesses normally take two frames: an address frame carrying the 16-bit register address, then a data frame with the operation. A skip flag drops the address frame when the PHY already holds the right register address. A post-increment read advances the register address field by one after it completes, so repeated commands walk consecutive registers.

The sequencer has four states. S_IDLE waits; a valid command write moves it to S_LAUNCH. S_LAUNCH loads the first frame and goes to S_ADDR_FRM (long form, no skip) or directly to S_DATA_FRM (short form, or skip set). S_ADDR_FRM moves to S_DATA_FRM after its 64th bit. S_DATA_FRM returns to S_IDLE after its 64th bit, clearing busy.

Top module: `mdio_station`

## Requirements
- R1: After reset all three registers read 0, MDC is low and the MDIO output enable is low.
- R2: reg_addr 0 selects the address register (26 bits: device 25:21, port 20:16, register 15:0), 1 the command word, 2 the 4-bit port mask; a read returns the stored value, zero-extended. The command word reads as busy at bit 22, clock select at 21:19, skip at 18, opcode at 17:16 and data at 15:0.
- R3: Writing the command word with bit 22 set and a nonzero opcode (1 write, 2 read with post-increment, 3 read) starts a transaction; bit 22 reads 1 until the last frame ends and 0 afterwards. With bit 22 clear, or opcode 0, nothing starts.
- R4: While busy, writes to any of the three registers are ignored.
- R5: MDC is high for HALF_MIN*(sel+1) clocks and low for the same count, where sel is the 3-bit clock select; MDC stays low while idle.
- R6: Every frame is 32 ones followed by 32 bits sent MSB first: start (2), opcode (2), port (5), device or register (5), turnaround 1 then 0, 16-bit payload.
- R7: A transaction is short form when the port field is below 4 and the mask bit indexed by it is 1; otherwise it is long form.
- R8: A long-form transaction with skip clear sends an address frame (start 00, opcode 00, payload = register field) before the data frame; with skip set, or in short form, only the data frame is sent.
- R9: Long-form data frames use start 00 and opcode 01 write, 11 read, 10 post-increment read, with the device field; short-form frames use start 01, opcode 01 write or 10 for either read code, with register bits 4:0 in the device slot.
- R10: In a read data frame the master releases MDIO from the first turnaround bit to the end, and the 16 bits sampled on rising MDC edges end up in the data field, first bit as MSB. After a write the data field keeps the written value.
- R11: A long-form post-increment read adds 1 to address bits 15:0 (wrapping, bits 25:16 unchanged) on completion; a short-form one leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
On every cycle the checker watches that the idle bus is quiet, that busy rises only on a register write and falls only out of the data frame, that the address register is frozen during a transaction, and that an address frame is always followed by a data frame. Frame contents, the choice between short and long form, the skip path, the MDC period per clock select, the read release and data capture, the post-increment wrap and the ignoring of writes while busy are shown only by the bench, which decodes every MDC rising edge with a PHY model and compares whole frames.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_LAUNCH   = 2'd1,
        S_ADDR_FRM = 2'd2,
        S_DATA_FRM = 2'd3
    } mdio_state_e;

    localparam int AW         = 26;
    localparam int FRAME_BITS = 64;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int REL_FIRST  = 46;
    localparam int RX_FIRST   = 48;

    localparam int BUSY_BIT = 22;
    localparam int SEL_LSB  = 19;
    localparam int SKIP_BIT = 18;
    localparam int CMD_LSB  = 16;

    localparam logic [1:0] CMD_WR    = 2'd1;
    localparam logic [1:0] CMD_RDINC = 2'd2;
    localparam logic [1:0] CMD_RD    = 2'd3;

    localparam logic [1:0] RSEL_ADDR  = 2'd0;
    localparam logic [1:0] RSEL_CMD   = 2'd1;
    localparam logic [1:0] RSEL_PORTS = 2'd2;

    localparam logic [31:0] PREAMBLE = 32'hFFFF_FFFF;
endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
    parameter int HALF_MIN = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       mdc,
    output logic       rise,
    output logic       bit_end
);
    localparam int HALF_MAX = HALF_MIN * 8;
    localparam int CW       = $clog2(HALF_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic [CW-1:0] half;
    logic          last;

    assign half = CW'(HALF_MIN * (32'(sel) + 32'd1));
    assign last = (cnt_q == half - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (last) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign mdc     = phase_q;
    assign rise    = run && last && !phase_q;
    assign bit_end = run && last && phase_q;
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt (
    input  logic        short_form,
    input  logic [1:0]  op,
    input  logic [4:0]  port,
    input  logic [4:0]  dev,
    input  logic [15:0] payload,
    output logic [31:0] frame
);
    logic [1:0] start_code;
    assign start_code = short_form ? 2'b01 : 2'b00;
    assign frame = {start_code, op, port, dev, 2'b10, payload};
endmodule

// File: rtl/mdio_station.sv
module mdio_station
    import mdio_pkg::*;
#(
    parameter int HALF_MIN  = 25,
    parameter int C22_PORTS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int PSEL_W = (C22_PORTS > 1) ? $clog2(C22_PORTS) : 1;

    mdio_state_e state_q, state_d;

    logic [AW-1:0]          addr_q;
    logic [C22_PORTS-1:0]   mask_q;
    logic [15:0]            data_q;
    logic [1:0]             cmd_q;
    logic                   skip_q;
    logic [2:0]             sel_q;
    logic                   busy_q;
    logic [FRAME_BITS-1:0]  shift_q;
    logic [BIT_W-1:0]       bit_q;

    logic        start, run, mdc_rise, mdc_end, frame_done;
    logic        is_c22, is_read;
    logic [1:0]  data_op;
    logic [4:0]  data_dev;
    logic [31:0] addr_frame, data_frame;
    logic        unused_wbits;

    assign unused_wbits = ^reg_wdata[31:AW];

    assign start = reg_wr && (reg_addr == RSEL_CMD) && reg_wdata[BUSY_BIT]
                   && (reg_wdata[CMD_LSB +: 2] != 2'b00) && !busy_q;
    assign is_c22 = (addr_q[20:16] < 5'(C22_PORTS)) && mask_q[addr_q[16 +: PSEL_W]];
    assign is_read = cmd_q[1];
    assign frame_done = mdc_end && (bit_q == BIT_W'(FRAME_BITS - 1));

    always_comb begin
        if (is_c22)                data_op = (cmd_q == CMD_WR) ? 2'b01 : 2'b10;
        else if (cmd_q == CMD_WR)  data_op = 2'b01;
        else if (cmd_q == CMD_RD)  data_op = 2'b11;
        else                       data_op = 2'b10;
    end
    assign data_dev = is_c22 ? addr_q[4:0] : addr_q[25:21];

    mdio_frame_fmt u_addr_fmt (
        .short_form (1'b0),
        .op         (2'b00),
        .port       (addr_q[20:16]),
        .dev        (addr_q[25:21]),
        .payload    (addr_q[15:0]),
        .frame      (addr_frame)
    );

    mdio_frame_fmt u_data_fmt (
        .short_form (is_c22),
        .op         (data_op),
        .port       (addr_q[20:16]),
        .dev        (data_dev),
        .payload    (data_q),
        .frame      (data_frame)
    );

    mdio_mdc_timer #(.HALF_MIN(HALF_MIN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sel     (sel_q),
        .mdc     (mdc),
        .rise    (mdc_rise),
        .bit_end (mdc_end)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_LAUNCH;
            S_LAUNCH:   state_d = (is_c22 || skip_q) ? S_DATA_FRM : S_ADDR_FRM;
            S_ADDR_FRM: if (frame_done) state_d = S_DATA_FRM;
            S_DATA_FRM: if (frame_done) state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            S_IDLE, S_LAUNCH: begin
                run     = 1'b0;
                mdio_oe = 1'b0;
            end
            S_ADDR_FRM: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
            end
            S_DATA_FRM: begin
                run     = 1'b1;
                mdio_oe = !(is_read && (bit_q >= BIT_W'(REL_FIRST)));
            end
        endcase
    end
    assign mdio_o = shift_q[FRAME_BITS-1];

    // registers and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            cmd_q   <= '0;
            skip_q  <= 1'b0;
            sel_q   <= '0;
            busy_q  <= 1'b0;
            shift_q <= '0;
            bit_q   <= '0;
        end else begin
            if (reg_wr && !busy_q) begin
                case (reg_addr)
                    RSEL_ADDR:  addr_q <= reg_wdata[AW-1:0];
                    RSEL_CMD: begin
                        data_q <= reg_wdata[15:0];
                        cmd_q  <= reg_wdata[CMD_LSB +: 2];
                        skip_q <= reg_wdata[SKIP_BIT];
                        sel_q  <= reg_wdata[SEL_LSB +: 3];
                    end
                    RSEL_PORTS: mask_q <= reg_wdata[C22_PORTS-1:0];
                    default: ;
                endcase
            end
            if (start) busy_q <= 1'b1;
            if (state_q == S_DATA_FRM && is_read && mdc_rise && bit_q >= BIT_W'(RX_FIRST))
                data_q <= {data_q[14:0], mdio_i};
            if (state_q == S_DATA_FRM && frame_done) begin
                busy_q <= 1'b0;
                if (cmd_q == CMD_RDINC && !is_c22)
                    addr_q[15:0] <= addr_q[15:0] + 16'd1;
            end
            if (state_q == S_LAUNCH) begin
                shift_q <= {PREAMBLE, (is_c22 || skip_q) ? data_frame : addr_frame};
                bit_q   <= '0;
            end else if (mdc_end) begin
                bit_q <= bit_q + BIT_W'(1);
                if (state_q == S_ADDR_FRM && frame_done)
                    shift_q <= {PREAMBLE, data_frame};
                else
                    shift_q <= {shift_q[FRAME_BITS-2:0], 1'b1};
            end
        end
    end

    // register read port
    always_comb begin
        case (reg_addr)
            RSEL_ADDR:  reg_rdata = 32'(addr_q);
            RSEL_CMD:   reg_rdata = {9'b0, busy_q, sel_q, skip_q, cmd_q, data_q};
            RSEL_PORTS: reg_rdata = 32'(mask_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_station_chk.sv
module mdio_station_chk
    import mdio_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          busy,
    input mdio_state_e   state,
    input logic          mdc,
    input logic          mdio_oe,
    input logic [AW-1:0] addr
);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr));

    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state) == S_DATA_FRM));

    // R4
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(addr)));

    // R8
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_FRM) |=> (state == S_ADDR_FRM || state == S_DATA_FRM));
endmodule

bind mdio_station mdio_station_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .busy    (busy_q),
    .state   (state_q),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .addr    (addr_q)
);

// File: tb/test_mdio_station.sv
module test_mdio_station;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_station #(.HALF_MIN(HALF), .C22_PORTS(4)) i_mdio_station (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int errors = 0;
    int checks = 0;

    // cycle counter
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY-side monitor: frames of 64 bits captured on rising MDC
    logic [63:0] cur = '0;
    logic [63:0] frames [32];
    int          bcnt = 0;
    int          nf = 0;
    int          rel_viol = 0;
    int          last_rise = 0;
    int          last_per = 0;
    logic [15:0] phy_val = '0;
    logic        rd_flag = 1'b0;

    always @(posedge mdc) begin
        if (bcnt >= 46 && cur[bcnt-35] && mdio_oe) rel_viol = rel_viol + 1;
        cur = {cur[62:0], (mdio_oe ? mdio_o : mdio_i)};
        last_per = cyc - last_rise;
        last_rise = cyc;
        bcnt = bcnt + 1;
        if (bcnt == 64) begin
            frames[nf % 32] = cur;
            nf = nf + 1;
            bcnt = 0;
        end
    end

    always @(negedge mdc) begin
        if (bcnt == 47) begin
            rd_flag = cur[12];
            mdio_i  = cur[12] ? 1'b0 : 1'b1;
        end else if (bcnt >= 48 && rd_flag) begin
            mdio_i = phy_val[63-bcnt];
        end else begin
            mdio_i = 1'b1;
        end
    end

    typedef struct packed {
        logic [31:0] areg;
        logic [3:0]  mask;
        logic [31:0] cmdw;
        logic [1:0]  nfr;
        logic [31:0] f0;
        logic [31:0] f1;
        logic [15:0] phy;
        logic [15:0] edata;
        logic [31:0] eareg;
        logic [7:0]  per;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        // long form write with address frame, sel 0
        '{32'h00A3_1234, 4'b0000, 32'h0041_BEEF, 2'd2,
          {2'b00,2'b00,5'd3,5'd5,2'b10,16'h1234},
          {2'b00,2'b01,5'd3,5'd5,2'b10,16'hBEEF},
          16'h0000, 16'hBEEF, 32'h00A3_1234, 8'd4},
        // long form read, skip set, sel 1
        '{32'h0029_0042, 4'b0000, 32'h004F_0000, 2'd1,
          {2'b00,2'b11,5'd9,5'd1,2'b10,16'hA5C3}, 32'h0,
          16'hA5C3, 16'hA5C3, 32'h0029_0042, 8'd8},
        // long form post-increment read, register wraps
        '{32'h00E0_FFFF, 4'b0000, 32'h0042_0000, 2'd2,
          {2'b00,2'b00,5'd0,5'd7,2'b10,16'hFFFF},
          {2'b00,2'b10,5'd0,5'd7,2'b10,16'h5A5A},
          16'h5A5A, 16'h5A5A, 32'h00E0_0000, 8'd4},
        // short form write, port 2
        '{32'h0002_0007, 4'b0100, 32'h0041_0F0F, 2'd1,
          {2'b01,2'b01,5'd2,5'd7,2'b10,16'h0F0F}, 32'h0,
          16'h0000, 16'h0F0F, 32'h0002_0007, 8'd4},
        // short form read, port 1, register 31, sel 2
        '{32'h0001_001F, 4'b0010, 32'h0053_0000, 2'd1,
          {2'b01,2'b10,5'd1,5'd31,2'b10,16'h1357}, 32'h0,
          16'h1357, 16'h1357, 32'h0001_001F, 8'd12},
        // port 2 but mask bit 0 only: long form
        '{32'h0062_0010, 4'b0001, 32'h0047_0000, 2'd1,
          {2'b00,2'b11,5'd2,5'd3,2'b10,16'h2468}, 32'h0,
          16'h2468, 16'h2468, 32'h0062_0010, 8'd4},
        // short form post-increment read: plain read, no increment
        '{32'h0003_0004, 4'b1000, 32'h0042_0000, 2'd1,
          {2'b01,2'b10,5'd3,5'd4,2'b10,16'hABCD}, 32'h0,
          16'hABCD, 16'hABCD, 32'h0003_0004, 8'd4}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] r;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(2'd1, r);
            if (!r[22]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic main_seq();
        logic [31:0] r;
        bit ok;
        int n0;

        repeat (5) @(negedge clk);
        // R1 reset state
        bus_rd(2'd0, r); chk(r == 0, "R1", "addr reg after reset", 64'(r), 64'h0);
        bus_rd(2'd1, r); chk(r == 0, "R1", "cmd reg after reset", 64'(r), 64'h0);
        bus_rd(2'd2, r); chk(r == 0, "R1", "mask reg after reset", 64'(r), 64'h0);
        chk(!mdc && !mdio_oe, "R1", "mdc/oe after reset", 64'({mdc, mdio_oe}), 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            phy_val = VEC[v].phy;
            bus_wr(2'd0, VEC[v].areg);
            bus_wr(2'd2, 32'(VEC[v].mask));
            bus_rd(2'd2, r);
            chk(r == 32'(VEC[v].mask), "R2", "mask readback", 64'(r), 64'(VEC[v].mask));
            n0 = nf;
            bus_wr(2'd1, VEC[v].cmdw);
            bus_rd(2'd1, r);
            chk(r[22] == 1'b1, "R3", "busy after start", 64'(r[22]), 64'h1);
            wait_idle(ok);
            chk(ok, "R3", "busy clears", 64'(ok), 64'h1);
            repeat (2) @(negedge clk);
            chk(nf - n0 == int'(VEC[v].nfr), "R8", "frame count", 64'(nf - n0), 64'(VEC[v].nfr));
            chk(frames[n0 % 32] == {32'hFFFF_FFFF, VEC[v].f0}, "R6", "first frame",
                frames[n0 % 32], {32'hFFFF_FFFF, VEC[v].f0});
            if (VEC[v].nfr == 2'd2)
                chk(frames[(n0 + 1) % 32] == {32'hFFFF_FFFF, VEC[v].f1}, "R9", "second frame",
                    frames[(n0 + 1) % 32], {32'hFFFF_FFFF, VEC[v].f1});
            bus_rd(2'd1, r);
            chk(r[15:0] == VEC[v].edata, "R10", "data field", 64'(r[15:0]), 64'(VEC[v].edata));
            chk(r[22] == 1'b0, "R3", "busy bit reads 0", 64'(r[22]), 64'h0);
            bus_rd(2'd0, r);
            chk(r == VEC[v].eareg, "R11", "address after op", 64'(r), 64'(VEC[v].eareg));
            chk(last_per == int'(VEC[v].per), "R5", "mdc period", 64'(last_per), 64'(VEC[v].per));
            chk(!mdc && !mdio_oe, "R5", "idle mdc low", 64'({mdc, mdio_oe}), 64'h0);
        end
        chk(rel_viol == 0, "R10", "mdio released in read", 64'(rel_viol), 64'h0);

        // R4: writes while busy are ignored
        phy_val = 16'h0;
        bus_wr(2'd0, 32'h0002_0007);
        bus_wr(2'd2, 32'h4);
        n0 = nf;
        bus_wr(2'd1, 32'h0041_0F0F);
        repeat (10) @(negedge clk);
        bus_wr(2'd1, 32'h0041_1111);
        bus_wr(2'd0, 32'h0000_0000);
        bus_wr(2'd2, 32'h0);
        bus_rd(2'd1, r);
        chk(r[15:0] == 16'h0F0F, "R4", "data kept while busy", 64'(r[15:0]), 64'h0F0F);
        bus_rd(2'd0, r);
        chk(r == 32'h0002_0007, "R4", "addr kept while busy", 64'(r), 64'h0002_0007);
        bus_rd(2'd2, r);
        chk(r == 32'h4, "R4", "mask kept while busy", 64'(r), 64'h4);
        wait_idle(ok);
        repeat (2) @(negedge clk);
        chk(nf - n0 == 1, "R4", "single transaction", 64'(nf - n0), 64'h1);
        chk(frames[n0 % 32] == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd7, 2'b10, 16'h0F0F},
            "R7", "short form frame", frames[n0 % 32],
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd7, 2'b10, 16'h0F0F});

        // R3: no start without busy bit or with opcode 0
        n0 = nf;
        bus_wr(2'd1, 32'h0001_2222);
        repeat (40) @(negedge clk);
        bus_rd(2'd1, r);
        chk(r[22] == 1'b0, "R3", "busy clear w/o start bit", 64'(r[22]), 64'h0);
        bus_wr(2'd1, 32'h0040_3333);
        repeat (40) @(negedge clk);
        bus_rd(2'd1, r);
        chk(r[22] == 1'b0, "R3", "busy clear with opcode 0", 64'(r[22]), 64'h0);
        chk(nf == n0 && bcnt == 0 && !mdc, "R3", "no mdc activity", 64'(nf - n0), 64'h0);
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        fork
            main_seq();
            begin
                repeat (190000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule